// File: doc/BRIEF.md
# Set-associative instruction cache

A read-only cache between an instruction fetch stage and a classic single-read bus. The fetch stage presents `addr_i` with `req_i`. This address is already a register output on the fetch side, so it drives the data memory read directly, and the memory gets a whole cycle for the read. The read result is captured in a register. In the next cycle that register is compared against the tag and valid arrays, and `valid_o` with `instr_o` comes out. While `stall_o` is high, the fetch stage holds its request unchanged until `valid_o` answers it.

Each way keeps its line data in a memory as wide as the bus. A line fills `LINE_ROWS` consecutive rows of that memory. On a miss the cache issues one bus read per row, starting at row 0 and going up, and writes each returned word into its row. The line's tag and valid bit are written only when the last beat arrives. Each set keeps its own tree pseudo-LRU bits, and these choose the way to replace. A single pulse on `inval_i` makes every line in every way invalid. Setting `NUM_WAYS` to 1 gives a direct-mapped cache.

Top module: `icache_sa`

## Requirements
- R1: After reset, `valid_o`, `stall_o`, `wb_cyc_o` and `wb_stb_o` are low, and every line is invalid, so the first access to any address misses.
- R2: On a hit, `valid_o` is high in the cycle after the request is presented. `instr_o` is the 32-bit word at that address: word k of a bus row sits in row bits [32k+31:32k].
- R3: A miss raises `stall_o` and keeps `valid_o` low. The next cycle starts a bus cycle that reads the line's rows in ascending order, starting at the row-0 address. Row r is at the line base plus r times `BUS_W/8`. `wb_stb_o` and `wb_adr_o` stay unchanged until `wb_ack_i`.
- R4: After a refill, the held request is answered with `valid_o` two cycles after the cycle in which the final acknowledge is presented.
- R5: Address bits split from low to high into byte-in-row, row-in-line, set index and tag. A set holds up to `NUM_WAYS` lines with different tags. A miss replaces the way that the set's tree pseudo-LRU bits select. Every hit and every completed refill turns those bits away from the way just used; with two ways this is least-recently-used.
- R6: An `inval_i` pulse clears the valid bit of every line in every way, so afterwards every previously cached line misses.
- R7: When `inval_i` arrives during a refill, the bus cycle ends at the acknowledge of the current beat and the line is not made valid. A later access to it misses and refills all of its rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request valid |
| addr_i | input | ADDR_W | Registered fetch byte address |
| inval_i | input | 1 | Invalidate every line |
| valid_o | output | 1 | `instr_o` answers the request of the previous cycle |
| instr_o | output | 32 | Fetched instruction word |
| stall_o | output | 1 | Request pending; hold `req_i` and `addr_i` |
| wb_cyc_o | output | 1 | Bus cycle active for the whole refill |
| wb_stb_o | output | 1 | Bus read strobe |
| wb_adr_o | output | ADDR_W | Bus byte address of the row being read |
| wb_dat_i | input | BUS_W | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge for one row |

## Verification
The bench builds the cache with 12-bit addresses, a 64-bit bus, two rows per line, four sets and two ways. With these values the whole cache is eight lines of four words. Every word of every line can be swept directly. Sequences over three tags per set run into evictions all the time, and a small least-recently-used model in the bench can predict each hit or miss and count each bus beat. Refill latency, beat addresses and the abort after one beat are all short enough to check to the exact cycle.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_SETTLE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/icache_plru.sv
module icache_plru #(
  parameter int NUM_WAYS  = 2,
  parameter int NUM_LINES = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(NUM_LINES)-1:0] rd_idx_i,
  output logic [((NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1)-1:0] victim_o,
  input  logic                       upd_i,
  input  logic [$clog2(NUM_LINES)-1:0] upd_idx_i,
  input  logic [((NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1)-1:0] upd_way_i
);
  localparam int LEVELS = $clog2(NUM_WAYS);
  localparam int WAY_W  = (NUM_WAYS > 1) ? LEVELS : 1;
  localparam int PW     = (NUM_WAYS > 1) ? NUM_WAYS - 1 : 1;

  logic [PW-1:0] tree_q [NUM_LINES];

  // walk the tree: node bit 0 -> left half, 1 -> right half
  function automatic logic [WAY_W-1:0] pick(input logic [PW-1:0] t);
    logic [WAY_W-1:0] w;
    int node;
    w = '0;
    node = 0;
    for (int l = 0; l < LEVELS; l++) begin
      w = (w << 1) | WAY_W'(t[node]);
      node = 2 * node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  function automatic logic [PW-1:0] touch(input logic [PW-1:0] t, input logic [WAY_W-1:0] way);
    logic [PW-1:0] r;
    int node;
    int b;
    r = t;
    node = 0;
    for (int l = 0; l < LEVELS; l++) begin
      b = int'((way >> (LEVELS - 1 - l)) & WAY_W'(1));
      r[node] = (b == 0);
      node = 2 * node + 1 + b;
    end
    return r;
  endfunction

  assign victim_o = pick(tree_q[rd_idx_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) tree_q[i] <= '0;
    end else if (upd_i) begin
      tree_q[upd_idx_i] <= touch(tree_q[upd_idx_i], upd_way_i);
    end
  end

  generate
    if (NUM_WAYS > 1) begin : g_chk
      assert_plru_away_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_i |=> pick(tree_q[$past(upd_idx_i)]) != $past(upd_way_i));
    end
  endgenerate
endmodule

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int NUM_WAYS  = 2,
  parameter int NUM_LINES = 32,
  parameter int TAG_W     = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(NUM_LINES)-1:0] lk_idx_i,
  input  logic [TAG_W-1:0]           lk_tag_i,
  output logic [NUM_WAYS-1:0]        hit_o,
  input  logic                       set_i,
  input  logic [((NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1)-1:0] set_way_i,
  input  logic [$clog2(NUM_LINES)-1:0] set_idx_i,
  input  logic [TAG_W-1:0]           set_tag_i,
  input  logic                       clr_i
);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [TAG_W-1:0]     tag_mem [NUM_LINES];
      logic [NUM_LINES-1:0] vld_q;
      logic                 wr;

      assign wr = set_i && (set_way_i == WAY_W'(w));

      always_ff @(posedge clk_i) begin
        if (wr) tag_mem[set_idx_i] <= set_tag_i;
      end

      // flush wins over a concurrent fill
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    vld_q <= '0;
        else if (clr_i) vld_q <= '0;
        else if (wr)    vld_q[set_idx_i] <= 1'b1;
      end

      assign hit_o[w] = vld_q[lk_idx_i] && (tag_mem[lk_idx_i] == lk_tag_i);

      assert_flush_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> vld_q == '0);
    end
  endgenerate

  assert_single_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int NUM_WAYS = 2,
  parameter int BUS_W    = 64,
  parameter int DEPTH    = 256
) (
  input  logic                              clk_i,
  input  logic [$clog2(DEPTH)-1:0]          rd_row_i,
  output logic [NUM_WAYS-1:0][BUS_W-1:0]    rd_data_o,
  input  logic                              we_i,
  input  logic [((NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1)-1:0] wr_way_i,
  input  logic [$clog2(DEPTH)-1:0]          wr_row_i,
  input  logic [BUS_W-1:0]                  wr_data_i
);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [BUS_W-1:0] mem [DEPTH];
      logic [BUS_W-1:0] rd_q;

      always_ff @(posedge clk_i) begin
        if (we_i && (wr_way_i == WAY_W'(w))) mem[wr_row_i] <= wr_data_i;
        rd_q <= mem[rd_row_i];
      end

      assign rd_data_o[w] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/icache_sa.sv
module icache_sa
  import icache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 64,
  parameter int LINE_ROWS = 8,
  parameter int NUM_LINES = 32,
  parameter int NUM_WAYS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inval_i,
  output logic              valid_o,
  output logic [31:0]       instr_o,
  output logic              stall_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic [BUS_W-1:0]  wb_dat_i,
  input  logic              wb_ack_i
);
  localparam int ROW_BYTES = BUS_W / 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);
  localparam int RIDX_W    = $clog2(LINE_ROWS);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int TAG_W     = ADDR_W - OFF_W - RIDX_W - IDX_W;
  localparam int RAM_AW    = IDX_W + RIDX_W;
  localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int WSEL_W    = OFF_W - 2;
  localparam int WSEL_WQ   = (WSEL_W > 0) ? WSEL_W : 1;

  fill_state_e state_q;
  logic                req_q;
  logic [TAG_W-1:0]    q_tag;
  logic [IDX_W-1:0]    q_idx;
  logic [WSEL_WQ-1:0]  q_wsel;
  logic [TAG_W-1:0]    miss_tag_q;
  logic [IDX_W-1:0]    miss_idx_q;
  logic [RIDX_W-1:0]   beat_q;
  logic [WAY_W-1:0]    victim_q;
  logic                abort_q;

  logic [NUM_WAYS-1:0]             hit_vec;
  logic [WAY_W-1:0]                hit_way;
  logic [WAY_W-1:0]                victim;
  logic [NUM_WAYS-1:0][BUS_W-1:0]  rd_data;
  logic [BUS_W-1:0]                row_sel;
  logic any_hit, last_beat, fill_ack, stop_fill, fill_done, start_fill;
  logic unused_addr_bits;

  assign unused_addr_bits = ^addr_i[1:0];

  // fetch-side stage: the RAM is addressed by addr_i itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      q_tag  <= '0;
      q_idx  <= '0;
      q_wsel <= '0;
    end else begin
      req_q  <= req_i;
      q_tag  <= addr_i[ADDR_W-1 -: TAG_W];
      q_idx  <= addr_i[OFF_W+RIDX_W +: IDX_W];
      q_wsel <= addr_i[2 +: WSEL_WQ];
    end
  end

  icache_tags #(.NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_idx_i(q_idx), .lk_tag_i(q_tag), .hit_o(hit_vec),
    .set_i(fill_done), .set_way_i(victim_q), .set_idx_i(miss_idx_q), .set_tag_i(miss_tag_q),
    .clr_i(inval_i)
  );

  icache_plru #(.NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES)) u_plru (
    .clk_i, .rst_ni,
    .rd_idx_i(q_idx), .victim_o(victim),
    .upd_i(valid_o || fill_done),
    .upd_idx_i(fill_done ? miss_idx_q : q_idx),
    .upd_way_i(fill_done ? victim_q : hit_way)
  );

  icache_data #(.NUM_WAYS(NUM_WAYS), .BUS_W(BUS_W), .DEPTH(NUM_LINES * LINE_ROWS)) u_data (
    .clk_i,
    .rd_row_i(addr_i[OFF_W +: RAM_AW]), .rd_data_o(rd_data),
    .we_i(fill_ack), .wr_way_i(victim_q), .wr_row_i({miss_idx_q, beat_q}), .wr_data_i(wb_dat_i)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign any_hit = |hit_vec;
  assign row_sel = rd_data[hit_way];

  generate
    if (WSEL_W > 0) begin : g_wsel
      logic [BUS_W-1:0] row_sh;
      assign row_sh  = row_sel >> {q_wsel, 5'b0};
      assign instr_o = row_sh[31:0];
    end else begin : g_nowsel
      assign instr_o = row_sel[31:0];
    end
  endgenerate

  assign valid_o    = (state_q == ST_IDLE) && req_q && any_hit;
  assign stall_o    = req_q && !valid_o;
  assign wb_cyc_o   = (state_q == ST_FILL);
  assign wb_stb_o   = (state_q == ST_FILL);
  assign wb_adr_o   = {miss_tag_q, miss_idx_q, beat_q, {OFF_W{1'b0}}};
  assign last_beat  = (beat_q == RIDX_W'(LINE_ROWS - 1));
  assign fill_ack   = (state_q == ST_FILL) && wb_ack_i;
  assign stop_fill  = fill_ack && (abort_q || inval_i);
  assign fill_done  = fill_ack && !abort_q && !inval_i && last_beat;
  assign start_fill = (state_q == ST_IDLE) && req_q && !any_hit && !inval_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      miss_tag_q <= '0;
      miss_idx_q <= '0;
      beat_q     <= '0;
      victim_q   <= '0;
      abort_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_fill) begin
          state_q    <= ST_FILL;
          miss_tag_q <= q_tag;
          miss_idx_q <= q_idx;
          victim_q   <= victim;
          beat_q     <= '0;
          abort_q    <= 1'b0;
        end
        ST_FILL: begin
          if (inval_i && !wb_ack_i) abort_q <= 1'b1;
          if (fill_ack) begin
            if (stop_fill)      state_q <= ST_IDLE;
            else if (last_beat) state_q <= ST_SETTLE;
            else                beat_q  <= beat_q + 1'b1;
          end
        end
        // one cycle so the output register reloads from the filled rows
        ST_SETTLE: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assert_miss_fills_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && req_q && !any_hit && !inval_i) |=> wb_cyc_o);

  assert_bus_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o)));

  assert_row_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i && !last_beat && !abort_q && !inval_i)
      |=> wb_adr_o == $past(wb_adr_o) + ADDR_W'(ROW_BYTES));

  assert_abort_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i && (abort_q || inval_i)) |=> !wb_cyc_o);

  assert_stall_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_o |-> !valid_o);
endmodule

// File: tb/icache_sa_bench.sv
`timescale 1ns/1ps
module icache_sa_bench;
  localparam int ADDR_W    = 12;
  localparam int BUS_W     = 64;
  localparam int LINE_ROWS = 2;
  localparam int NUM_LINES = 4;
  localparam int NUM_WAYS  = 2;
  localparam int ROW_BYTES = BUS_W / 8;
  localparam int LINE_B    = ROW_BYTES * LINE_ROWS;
  localparam int MISS_LAT  = 3 + 2 * LINE_ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic inval = 1'b0;
  logic valid, stall, cyc, stb, ack;
  logic [31:0] instr;
  logic [ADDR_W-1:0] adr;
  logic [BUS_W-1:0] dat;

  int n_tests = 0;
  int n_fail  = 0;
  int beats   = 0;
  logic [ADDR_W-1:0] beat_log [16];

  int  tag_m [NUM_LINES][NUM_WAYS];
  bit  vld_m [NUM_LINES][NUM_WAYS];
  int  lru_m [NUM_LINES];

  always #2.5 clk = ~clk;

  icache_sa #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LINE_ROWS(LINE_ROWS),
              .NUM_LINES(NUM_LINES), .NUM_WAYS(NUM_WAYS)) u_icache_sa (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .inval_i(inval),
    .valid_o(valid), .instr_o(instr), .stall_o(stall),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_adr_o(adr), .wb_dat_i(dat), .wb_ack_i(ack)
  );

  function automatic logic [31:0] mem_word(int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  // behavioural memory: one acknowledge every other cycle while strobed
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      dat <= '0;
    end else begin
      ack <= cyc && stb && !ack;
      dat <= {mem_word(int'(adr) + 4), mem_word(int'(adr))};
      if (cyc && stb && ack) begin
        beat_log[beats % 16] <= adr;
        beats <= beats + 1;
      end
    end
  end

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NUM_LINES; s++)
      for (int w = 0; w < NUM_WAYS; w++) vld_m[s][w] = 1'b0;
  endtask

  task automatic fetch(int a, string phase_rq);
    int s, t, hw, b0, lat;
    bit exp_hit, first_stall;
    s = (a / LINE_B) % NUM_LINES;
    t = a / (LINE_B * NUM_LINES);
    exp_hit = 1'b0;
    hw = 0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (vld_m[s][w] && tag_m[s][w] == t) begin exp_hit = 1'b1; hw = w; end
    b0 = beats;
    req  = 1'b1;
    addr = ADDR_W'(a);
    @(negedge clk);
    lat = 1;
    first_stall = stall;
    while (!valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check(valid, "R2", "valid_o answer", longint'(valid), 1);
    check(instr == mem_word(a), "R2", "instruction word", instr, mem_word(a));
    check((beats - b0) == (exp_hit ? 0 : LINE_ROWS), phase_rq, "hit/miss beat count",
          beats - b0, exp_hit ? 0 : LINE_ROWS);
    if (exp_hit) begin
      check(lat == 1, "R2", "hit latency", lat, 1);
      lru_m[s] = 1 - hw;
    end else begin
      check(lat == MISS_LAT, "R4", "refill latency", lat, MISS_LAT);
      check(first_stall, "R3", "stall_o on miss", longint'(first_stall), 1);
      for (int r = 0; r < LINE_ROWS; r++)
        check(int'(beat_log[(b0 + r) % 16]) == (a / LINE_B) * LINE_B + r * ROW_BYTES,
              "R3", "row address order", beat_log[(b0 + r) % 16],
              (a / LINE_B) * LINE_B + r * ROW_BYTES);
      hw = lru_m[s];
      tag_m[s][hw] = t;
      vld_m[s][hw] = 1'b1;
      lru_m[s] = 1 - hw;
    end
  endtask

  task automatic pulse_inval();
    req   = 1'b0;
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int b0, n;
    model_clear();
    for (int s = 0; s < NUM_LINES; s++) lru_m[s] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid, "R1", "valid_o after reset", longint'(valid), 0);
    check(!stall, "R1", "stall_o after reset", longint'(stall), 0);
    check(!cyc && !stb, "R1", "bus idle after reset", longint'({cyc, stb}), 0);

    // every word of every line, two tags per set: fills both ways
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < NUM_LINES; s++)
        for (int w = 0; w < LINE_B / 4; w++)
          fetch(t * LINE_B * NUM_LINES + s * LINE_B + w * 4, "R1");

    // three tags per set force replacements; model predicts each victim (R5)
    lf = 16'hACE1;
    for (int i = 0; i < 160; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fetch((int'(lf[9:8]) % 3) * LINE_B * NUM_LINES + int'(lf[5:4]) * LINE_B
            + int'(lf[3:2]) * 4, "R5");
    end

    // whole-cache invalidate: every line previously cached must refill (R6)
    pulse_inval();
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < NUM_LINES; s++) begin
        b0 = beats;
        fetch(t * LINE_B * NUM_LINES + s * LINE_B + 4, "R6");
        check((beats - b0) == LINE_ROWS, "R6", "miss after invalidate", beats - b0, LINE_ROWS);
      end

    // invalidate during refill: one beat then the bus cycle ends (R7)
    b0 = beats;
    req  = 1'b1;
    addr = ADDR_W'(3 * LINE_B * NUM_LINES + 1 * LINE_B);
    n = 0;
    while (!cyc && n < 20) begin @(negedge clk); n++; end
    check(cyc, "R7", "refill started", longint'(cyc), 1);
    req   = 1'b0;
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    n = 0;
    while (cyc && n < 20) begin @(negedge clk); n++; end
    check(!cyc, "R7", "bus cycle dropped", longint'(cyc), 0);
    check((beats - b0) == 1, "R7", "beats before abort", beats - b0, 1);
    model_clear();
    repeat (2) @(negedge clk);
    b0 = beats;
    fetch(3 * LINE_B * NUM_LINES + 1 * LINE_B + 8, "R7");
    check((beats - b0) == LINE_ROWS, "R7", "aborted line refills fully", beats - b0, LINE_ROWS);
    fetch(3 * LINE_B * NUM_LINES + 1 * LINE_B + 12, "R7");

    req = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule